// File: doc/BRIEF.md
# Stepper Driver Power-Mode Controller

This synchronous controller decides which of five internal subsystems of a stepper-motor driver are switched on. The five are the output bridge, the charge pump, the step indexer, the digital supply and the analog supply. It takes an active-low sleep request, a drive-enable input, a supply-undervoltage flag and a vector of auxiliary fault flags (charge-pump undervoltage, overcurrent, overtemperature). All of these are synchronous to the clock.

A four-state power sequencer handles the timing. It counts a programmable delay before it commits to sleep, and a second programmable delay after wake-up during which the bridge stays off. The states are RUN, PEND (sleep entry pending), SLEEP and WAKE. Its transitions are:
- RUN→PEND when the request goes low.
- PEND→RUN when the request returns high (cancel).
- PEND→SLEEP when the sleep count expires.
- SLEEP→WAKE when the request goes high.
- WAKE→PEND when the request goes low.
- WAKE→RUN when the wake count expires.

A combinational map turns the state, the enable input and the faults into the five enables and a status code. A small step-position counter shows how the indexer behaves while the bridge is off. Its bridge-side copy only follows it while the bridge is enabled.

Top module: `mdrv_mode_ctrl`

## Requirements
- R1: In RUN with drive enable high and no fault, all five enables are 1 and the mode output is 0 (operating).
- R2: In RUN with drive enable low and no fault, only the bridge enable is 0, and the mode output is 1 (disabled).
- R3: A rising step edge advances pos_o by one while the indexer is enabled, even with the bridge off. bridge_pos_o copies pos_o one cycle later only while the bridge enable is 1, and holds otherwise.
- R4: After the awake request is sampled low in RUN, the mode output is 2 (sleep pending) for sleep_dly_i+1 cycles. During that time the normal enable map applies. Then the mode output is 3 (sleep) and all five enables are 0.
- R5: After the awake request is sampled high in SLEEP, the mode output is 4 (waking) for wake_dly_i+1 cycles. During that time the bridge enable is 0 and the other four follow the fault map. Afterwards the block is in RUN.
- R6: A supply undervoltage outside SLEEP leaves only the digital-supply enable at 1, whatever the drive enable and the other faults are. In RUN the mode output is 5 (fault).
- R7: Any auxiliary fault without undervoltage clears only the bridge enable. In RUN the mode output is 5.
- R8: The awake request returning high while sleep entry is pending brings the block back to RUN on the next cycle.
- R9: Step edges in SLEEP or during undervoltage leave pos_o unchanged.
- R10: pos_o becomes 0 on the clock edge that samples undervoltage deasserted after it was asserted.
- R11: Reset puts the block in WAKE (mode 4) with pos_o and bridge_pos_o at 0. A step input already high at reset is not counted as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| awake_req_i | input | 1 | High keeps the device awake, low requests sleep |
| drv_en_i | input | 1 | Drive enable for the output bridge |
| uv_flt_i | input | 1 | Supply-undervoltage fault |
| aux_flt_i | input | AUX_FLT_N | Charge-pump UV, overcurrent, overtemperature faults |
| step_i | input | 1 | Step pulse input |
| sleep_dly_i | input | SLP_W | Sleep-entry delay count |
| wake_dly_i | input | WAK_W | Wake-up delay count |
| bridge_en_o | output | 1 | Output bridge enable |
| pump_en_o | output | 1 | Charge pump enable |
| index_en_o | output | 1 | Step indexer enable |
| dsup_en_o | output | 1 | Digital supply enable |
| asup_en_o | output | 1 | Analog supply enable |
| mode_o | output | 3 | Mode code 0..5 (see R1-R7 texts) |
| pos_o | output | POS_W | Indexer step position |
| bridge_pos_o | output | POS_W | Position presented by the bridge |

## Verification
A sequencer stuck in the wrong state shows at mode_o and the enables in the same cycle, because both are decoded combinationally from the state. A miscounted delay shows one cycle early or late on the PEND-to-SLEEP and WAKE-to-RUN transitions, which the bench samples cycle by cycle. An indexer error shows on pos_o one cycle after the offending edge. Its bridge-side copy lags by a further cycle, so a copy made while the bridge is off shows as a changed bridge_pos_o.

// File: rtl/mdrv_pkg.sv
package mdrv_pkg;

    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_PEND  = 2'd1,
        PS_SLEEP = 2'd2,
        PS_WAKE  = 2'd3
    } pwr_st_e;

    typedef enum logic [2:0] {
        MD_OPER  = 3'd0,
        MD_DIS   = 3'd1,
        MD_PEND  = 3'd2,
        MD_SLEEP = 3'd3,
        MD_WAKE  = 3'd4,
        MD_FAULT = 3'd5
    } mode_e;

    typedef struct packed {
        logic bridge;
        logic pump;
        logic indexer;
        logic dsup;
        logic asup;
    } sub_en_t;

endpackage

// File: rtl/mdrv_pwr_fsm.sv
module mdrv_pwr_fsm
    import mdrv_pkg::*;
#(
    parameter int SLP_W = 8,
    parameter int WAK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             awake_req_i,
    input  logic [SLP_W-1:0] sleep_dly_i,
    input  logic [WAK_W-1:0] wake_dly_i,
    output pwr_st_e          state_o
);
    localparam int CNT_W = (SLP_W > WAK_W) ? SLP_W : WAK_W;

    pwr_st_e            state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [CNT_W-1:0]   slp_lim, wak_lim;

    assign slp_lim = CNT_W'(sleep_dly_i);
    assign wak_lim = CNT_W'(wake_dly_i);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PS_RUN: begin
                if (!awake_req_i) begin
                    state_d = PS_PEND;
                    cnt_d   = '0;
                end
            end
            PS_PEND: begin
                if (awake_req_i) begin
                    state_d = PS_RUN;
                end else if (cnt_q >= slp_lim) begin
                    state_d = PS_SLEEP;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PS_SLEEP: begin
                if (awake_req_i) begin
                    state_d = PS_WAKE;
                    cnt_d   = '0;
                end
            end
            PS_WAKE: begin
                if (!awake_req_i) begin
                    state_d = PS_PEND;
                    cnt_d   = '0;
                end else if (cnt_q >= wak_lim) begin
                    state_d = PS_RUN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = PS_WAKE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_WAKE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/mdrv_enable_map.sv
module mdrv_enable_map
    import mdrv_pkg::*;
#(
    parameter int AUX_FLT_N = 3
) (
    input  pwr_st_e              state_i,
    input  logic                 drv_en_i,
    input  logic                 uv_flt_i,
    input  logic [AUX_FLT_N-1:0] aux_flt_i,
    output sub_en_t              en_o,
    output mode_e                mode_o
);
    localparam sub_en_t EN_ALL    = '{bridge: 1'b1, pump: 1'b1, indexer: 1'b1, dsup: 1'b1, asup: 1'b1};
    localparam sub_en_t EN_NO_BR  = '{bridge: 1'b0, pump: 1'b1, indexer: 1'b1, dsup: 1'b1, asup: 1'b1};
    localparam sub_en_t EN_DSUP   = '{bridge: 1'b0, pump: 1'b0, indexer: 1'b0, dsup: 1'b1, asup: 1'b0};
    localparam sub_en_t EN_NONE   = '0;

    logic    any_aux;
    sub_en_t awake_en;
    mode_e   awake_mode;

    assign any_aux = |aux_flt_i;

    // Awake map: undervoltage beats auxiliary faults, faults beat enable.
    always_comb begin
        if (uv_flt_i) begin
            awake_en   = EN_DSUP;
            awake_mode = MD_FAULT;
        end else if (any_aux) begin
            awake_en   = EN_NO_BR;
            awake_mode = MD_FAULT;
        end else if (!drv_en_i) begin
            awake_en   = EN_NO_BR;
            awake_mode = MD_DIS;
        end else begin
            awake_en   = EN_ALL;
            awake_mode = MD_OPER;
        end
    end

    // Output process: power state overrides the awake map.
    always_comb begin
        unique case (state_i)
            PS_RUN: begin
                en_o   = awake_en;
                mode_o = awake_mode;
            end
            PS_PEND: begin
                en_o   = awake_en;
                mode_o = MD_PEND;
            end
            PS_SLEEP: begin
                en_o   = EN_NONE;
                mode_o = MD_SLEEP;
            end
            PS_WAKE: begin
                en_o        = awake_en;
                en_o.bridge = 1'b0;
                mode_o      = MD_WAKE;
            end
            default: begin
                en_o   = EN_NONE;
                mode_o = MD_SLEEP;
            end
        endcase
    end

endmodule

// File: rtl/mdrv_step_indexer.sv
module mdrv_step_indexer #(
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             index_en_i,
    input  logic             bridge_en_i,
    input  logic             uv_flt_i,
    output logic [POS_W-1:0] pos_o,
    output logic [POS_W-1:0] bridge_pos_o
);
    logic             step_q;
    logic             step_vld_q;
    logic             uv_q;
    logic             step_rise;
    logic             uv_exit;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] bpos_q;

    assign step_rise = step_vld_q & step_i & ~step_q;
    assign uv_exit   = uv_q & ~uv_flt_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q     <= 1'b0;
            step_vld_q <= 1'b0;
            uv_q       <= 1'b0;
        end else begin
            step_q     <= step_i;
            step_vld_q <= 1'b1;
            uv_q       <= uv_flt_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (uv_exit) begin
            pos_q <= '0;
        end else if (step_rise && index_en_i) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bpos_q <= '0;
        end else if (bridge_en_i) begin
            bpos_q <= pos_q;
        end
    end

    assign pos_o        = pos_q;
    assign bridge_pos_o = bpos_q;

endmodule

// File: rtl/mdrv_mode_ctrl.sv
module mdrv_mode_ctrl
    import mdrv_pkg::*;
#(
    parameter int SLP_W     = 8,
    parameter int WAK_W     = 8,
    parameter int POS_W     = 8,
    parameter int AUX_FLT_N = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 awake_req_i,
    input  logic                 drv_en_i,
    input  logic                 uv_flt_i,
    input  logic [AUX_FLT_N-1:0] aux_flt_i,
    input  logic                 step_i,
    input  logic [SLP_W-1:0]     sleep_dly_i,
    input  logic [WAK_W-1:0]     wake_dly_i,
    output logic                 bridge_en_o,
    output logic                 pump_en_o,
    output logic                 index_en_o,
    output logic                 dsup_en_o,
    output logic                 asup_en_o,
    output logic [2:0]           mode_o,
    output logic [POS_W-1:0]     pos_o,
    output logic [POS_W-1:0]     bridge_pos_o
);
    pwr_st_e pwr_st;
    sub_en_t sub_en;
    mode_e   mode;

    mdrv_pwr_fsm #(
        .SLP_W (SLP_W),
        .WAK_W (WAK_W)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .awake_req_i (awake_req_i),
        .sleep_dly_i (sleep_dly_i),
        .wake_dly_i  (wake_dly_i),
        .state_o     (pwr_st)
    );

    mdrv_enable_map #(
        .AUX_FLT_N (AUX_FLT_N)
    ) map_i (
        .state_i   (pwr_st),
        .drv_en_i  (drv_en_i),
        .uv_flt_i  (uv_flt_i),
        .aux_flt_i (aux_flt_i),
        .en_o      (sub_en),
        .mode_o    (mode)
    );

    mdrv_step_indexer #(
        .POS_W (POS_W)
    ) idx_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_i       (step_i),
        .index_en_i   (sub_en.indexer),
        .bridge_en_i  (sub_en.bridge),
        .uv_flt_i     (uv_flt_i),
        .pos_o        (pos_o),
        .bridge_pos_o (bridge_pos_o)
    );

    assign bridge_en_o = sub_en.bridge;
    assign pump_en_o   = sub_en.pump;
    assign index_en_o  = sub_en.indexer;
    assign dsup_en_o   = sub_en.dsup;
    assign asup_en_o   = sub_en.asup;
    assign mode_o      = mode;

endmodule

// File: rtl/mdrv_mode_ctrl_chk.sv
module mdrv_mode_ctrl_chk #(
    parameter int POS_W     = 8,
    parameter int AUX_FLT_N = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 awake_req_i,
    input logic                 uv_flt_i,
    input logic [AUX_FLT_N-1:0] aux_flt_i,
    input logic                 bridge_en_o,
    input logic                 pump_en_o,
    input logic                 index_en_o,
    input logic                 dsup_en_o,
    input logic                 asup_en_o,
    input logic [2:0]           mode_o,
    input logic [POS_W-1:0]     bridge_pos_o
);
    logic [4:0] en_vec;
    assign en_vec = {bridge_en_o, pump_en_o, index_en_o, dsup_en_o, asup_en_o};

    // R1
    oper_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0) |-> (en_vec == 5'b11111));

    // R2
    dis_bridge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd1) |-> (en_vec == 5'b01111));

    // R3
    bridge_pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bridge_en_o |=> $stable(bridge_pos_o));

    // R4
    sleep_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd3) |-> (en_vec == 5'b00000));

    // R5
    wake_bridge_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4) |-> !bridge_en_o);

    // R6
    uv_dsup_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_flt_i && mode_o != 3'd3) |-> (en_vec == 5'b00010));

    // R7
    aux_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!uv_flt_i && (|aux_flt_i) && mode_o != 3'd3) |-> (en_vec == 5'b01111));

    // R8
    pend_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd2 && awake_req_i) |=> (mode_o != 3'd2 && mode_o != 3'd3));

endmodule

bind mdrv_mode_ctrl mdrv_mode_ctrl_chk #(
    .POS_W     (POS_W),
    .AUX_FLT_N (AUX_FLT_N)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .awake_req_i  (awake_req_i),
    .uv_flt_i     (uv_flt_i),
    .aux_flt_i    (aux_flt_i),
    .bridge_en_o  (bridge_en_o),
    .pump_en_o    (pump_en_o),
    .index_en_o   (index_en_o),
    .dsup_en_o    (dsup_en_o),
    .asup_en_o    (asup_en_o),
    .mode_o       (mode_o),
    .bridge_pos_o (bridge_pos_o)
);

// File: tb/mdrv_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module mdrv_mode_ctrl_tb_top;
    localparam int SLP_W = 8;
    localparam int WAK_W = 8;
    localparam int POS_W = 8;
    localparam int AFN   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic awake_req = 1'b1;
    logic drv_en = 1'b0;
    logic uv = 1'b0;
    logic [AFN-1:0] aux = '0;
    logic step = 1'b0;
    logic [SLP_W-1:0] sdly = 8'd3;
    logic [WAK_W-1:0] wdly = 8'd2;
    logic br, pu, ix, ds, as_;
    logic [2:0] mode;
    logic [POS_W-1:0] pos, bpos;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mdrv_mode_ctrl #(.SLP_W(SLP_W), .WAK_W(WAK_W), .POS_W(POS_W), .AUX_FLT_N(AFN)) dut_i (
        .clk(clk), .rst_n(rst_n), .awake_req_i(awake_req), .drv_en_i(drv_en),
        .uv_flt_i(uv), .aux_flt_i(aux), .step_i(step), .sleep_dly_i(sdly),
        .wake_dly_i(wdly), .bridge_en_o(br), .pump_en_o(pu), .index_en_o(ix),
        .dsup_en_o(ds), .asup_en_o(as_), .mode_o(mode), .pos_o(pos),
        .bridge_pos_o(bpos)
    );

    // {drv_en, uv, aux[2:0]} -> {bridge,pump,index,dsup,asup}, mode
    localparam int NV = 8;
    localparam logic [12:0] VEC [NV] = '{
        {5'b1_0_000, 5'b11111, 3'd0},
        {5'b0_0_000, 5'b01111, 3'd1},
        {5'b1_0_001, 5'b01111, 3'd5},
        {5'b1_0_010, 5'b01111, 3'd5},
        {5'b1_0_100, 5'b01111, 3'd5},
        {5'b0_0_110, 5'b01111, 3'd5},
        {5'b1_1_000, 5'b00010, 3'd5},
        {5'b0_1_111, 5'b00010, 3'd5}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_step();
        step = 1'b1;
        tick();
        step = 1'b0;
        tick();
    endtask

    function automatic int env();
        return int'({br, pu, ix, ds, as_});
    endfunction

    initial begin
        step = 1'b1;          // R11: high through reset, must not count
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state: waking, bridge off
        chk("R11 mode", int'(mode), 4);
        chk("R11 pos", int'(pos), 0);
        chk("R11 bpos", int'(bpos), 0);
        // R5: wake lasts wdly+1 cycles counting the reset cycle
        tick();
        chk("R5 wake c2", int'(mode), 4);
        chk("R11 first-cycle step ignored", int'(pos), 0);
        tick();
        chk("R5 wake c3", int'(mode), 4);
        chk("R5 wake bridge", int'(br), 0);
        tick();
        chk("R5 wake done", int'(mode), 1);
        step = 1'b0;
        tick();

        // R1 R2 R6 R7 vector table, state RUN
        for (int i = 0; i < NV; i++) begin
            {drv_en, uv, aux} = VEC[i][12:8];
            #1;
            chk("R1/R2/R6/R7 enables", env(), int'(VEC[i][7:3]));
            chk("R1/R2/R6/R7 mode", int'(mode), int'(VEC[i][2:0]));
            @(negedge clk);
        end
        uv = 1'b0; aux = '0; drv_en = 1'b0;
        tick(); // uv exit clears pos (still 0)

        // R3: steps advance while bridge off; bridge copy holds
        pulse_step();
        pulse_step();
        chk("R3 pos while disabled", int'(pos), 2);
        chk("R3 bridge pos held", int'(bpos), 0);
        drv_en = 1'b1;
        tick();
        chk("R3 bridge pos follows", int'(bpos), 2);

        // R9 + R10: undervoltage ignores steps, exit clears
        uv = 1'b1;
        pulse_step();
        chk("R9 uv step ignored", int'(pos), 2);
        uv = 1'b0;
        tick();
        chk("R10 pos cleared", int'(pos), 0);
        tick();

        // R8: cancel during pending
        awake_req = 1'b0;
        tick();
        chk("R8 pend", int'(mode), 2);
        tick();
        awake_req = 1'b1;
        tick();
        chk("R8 cancel to run", int'(mode), 0);

        // R4: pending for sdly+1 cycles, then sleep
        awake_req = 1'b0;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R4 pending", int'(mode), 2);
            chk("R4 pending bridge", int'(br), 1);
        end
        tick();
        chk("R4 sleep mode", int'(mode), 3);
        chk("R4 sleep enables", env(), 0);

        // R9: step in sleep ignored
        pulse_step();
        chk("R9 sleep step ignored", int'(pos), 0);

        // R5: wake from sleep lasts wdly+1 cycles
        awake_req = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R5 waking", int'(mode), 4);
            chk("R5 waking enables", env(), 5'b01111);
        end
        tick();
        chk("R5 back to run", int'(mode), 0);

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule